// File: doc/BRIEF.md
# SPI Register-Bus Flag Clearing Logic

This block is the host-facing register side of a serial peripheral. It holds a receive buffer and a transmit buffer, each two bytes wide, together with two handshake flags: `rx_full`, raised when the shift engine delivers a finished frame, and `tx_empty`, raised when the shift engine has taken the buffered transmit data. Software clears either flag only with a two-step sequence. First it reads the status register while the flag is set, which arms that flag. Then it accesses the low data byte: a read for `rx_full`, a write for `tx_empty`.

A mode input selects 8-bit or 16-bit transfers. The data register is split into a high and a low byte half. Each bus access carries byte enables, so software can touch one half or both halves in one word access. Accesses to the high half alone never clear a flag, so software can fetch or stage the high byte first and finish with the low byte. Data writes are ignored while `tx_empty` is low, which protects a buffer the engine has not yet taken. Read data is registered and appears one cycle after the strobe.

Top module: `spi_regif`

## Requirements
- R1: While reset is held and after it is released, `rx_full`=0, `tx_empty`=1, `tx_data`=0, `tx_valid`=0 and `bus_rdata`=0.
- R2: A status read (`bus_addr`=0, `bus_we`=0) returns `rx_full` in bit 0 and `tx_empty` in bit 1, with all other bits 0. `bus_rdata` takes this value on the clock edge that ends the strobe cycle.
- R3: `rx_full` falls only on a data read whose `bus_be[0]`=1, and only when a status read that saw `rx_full`=1 came before it. A low-byte data read that is not armed leaves `rx_full` set.
- R4: In 16-bit mode, a data read with `bus_be`=2'b10 returns the received high byte in bits 15:8 and 0 elsewhere. Such reads never clear `rx_full` and do not disarm it, however many are made.
- R5: In 16-bit mode, an armed word read (`bus_be`=2'b11) returns the whole received word and clears `rx_full`.
- R6: A pulse on `rx_done` loads `rx_frame` into the receive buffer (only the low byte in 8-bit mode, with the high byte zeroed), sets `rx_full` and disarms it. A low-byte read that follows and has no new status read does not clear the flag.
- R7: `tx_empty` falls only on a data write whose `bus_be[0]`=1, and only when a status read that saw `tx_empty`=1 came before it. An unarmed write stores its bytes but leaves `tx_empty` at 1.
- R8: While `tx_empty`=0, data writes to either byte leave the transmit buffer unchanged.
- R9: In 16-bit mode, writes with `bus_be`=2'b10 store the high byte and never clear `tx_empty`. An armed word write stores both bytes and clears `tx_empty`.
- R10: `tx_take` while `tx_empty`=0 sets `tx_empty` on the next edge and disarms it. `tx_take` while `tx_empty`=1 has no effect.
- R11: In 8-bit mode (`wide_mode`=0), bits 15:8 of `tx_data` and of data read results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 0 = 8-bit transfers, 1 = 16-bit transfers |
| bus_req | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status register, 1 = data register |
| bus_be | input | 2 | Byte enables: bit 1 = high half, bit 0 = low half |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| rx_full | output | 1 | Receive-full flag |
| tx_empty | output | 1 | Transmit-empty flag |
| tx_data | output | 16 | Transmit buffer to the shift engine |
| tx_valid | output | 1 | Transmit buffer holds data not yet taken |
| tx_take | input | 1 | Shift engine accepts the transmit buffer |
| rx_done | input | 1 | Shift engine delivers a frame |
| rx_frame | input | 16 | Frame delivered with `rx_done` |

## Verification
The hardest case to reach is an armed flag that a new transfer event disarms before the clearing access arrives. The bench reads status while `rx_full` is set, then pulses `rx_done` before the low-byte read, and checks that the read returns the new frame while the flag stays up. A second case is reaching the no-effect window for writes. The bench clears `tx_empty` through the armed sequence first and holds `tx_take` low, so it can show at `tx_data` that later word writes do not land.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int STAT_RXF_BIT = 0;
  localparam int STAT_TXE_BIT = 1;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_STAT  = 2'd1,
    ACC_DRD   = 2'd2,
    ACC_DWR   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/spi_regif_flag.sv
module spi_regif_flag #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic stat_rd,
  input  logic clr_acc,
  output logic flag_q,
  output logic arm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= RESET_VAL;
      arm_q  <= 1'b0;
    end else if (set_evt) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (clr_acc && arm_q) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (stat_rd && flag_q) begin
      arm_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_regif_txbuf.sv
module spi_regif_txbuf #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide_mode,
  input  logic          wr_ok,
  input  logic [1:0]    be,
  input  logic [2*BW-1:0] wdata,
  output logic [2*BW-1:0] tx_data
);
  logic [BW-1:0] byte_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) byte_q[g] <= '0;
      else if (wr_ok && be[g]) byte_q[g] <= wdata[g*BW +: BW];
    end
  end

  assign tx_data = wide_mode ? {byte_q[1], byte_q[0]} : {{BW{1'b0}}, byte_q[0]};
endmodule

// File: rtl/spi_regif_rxbuf.sv
module spi_regif_rxbuf #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wide_mode,
  input  logic            load,
  input  logic [2*BW-1:0] frame,
  input  logic [1:0]      be,
  output logic [2*BW-1:0] rd_view
);
  logic [2*BW-1:0] buf_q;
  logic [2*BW-1:0] shown;

  always_ff @(posedge clk) begin
    if (rst) buf_q <= '0;
    else if (load) buf_q <= wide_mode ? frame : {{BW{1'b0}}, frame[BW-1:0]};
  end

  assign shown = wide_mode ? buf_q : {{BW{1'b0}}, buf_q[BW-1:0]};
  assign rd_view = {shown[2*BW-1:BW] & {BW{be[1]}}, shown[BW-1:0] & {BW{be[0]}}};
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide_mode,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [1:0]    bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rx_full,
  output logic          tx_empty,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_take,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_frame
);
  acc_kind_e     acc;
  logic          lo_hit;
  logic          rx_arm, tx_arm;
  logic [DW-1:0] rx_view;
  logic [DW-1:0] stat_word;

  always_comb begin
    acc = ACC_NONE;
    if (bus_req) begin
      if (!bus_addr) acc = bus_we ? ACC_NONE : ACC_STAT;
      else           acc = bus_we ? ACC_DWR  : ACC_DRD;
    end
  end

  assign lo_hit = bus_be[0];

  spi_regif_flag #(.RESET_VAL(1'b0)) u_rxf (
    .clk(clk), .rst(rst),
    .set_evt(rx_done),
    .stat_rd(acc == ACC_STAT),
    .clr_acc((acc == ACC_DRD) && lo_hit),
    .flag_q(rx_full), .arm_q(rx_arm)
  );

  spi_regif_flag #(.RESET_VAL(1'b1)) u_txe (
    .clk(clk), .rst(rst),
    .set_evt(tx_take && !tx_empty),
    .stat_rd(acc == ACC_STAT),
    .clr_acc((acc == ACC_DWR) && lo_hit && tx_empty),
    .flag_q(tx_empty), .arm_q(tx_arm)
  );

  spi_regif_txbuf #(.BW(BW)) u_txb (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .wr_ok((acc == ACC_DWR) && tx_empty),
    .be(bus_be), .wdata(bus_wdata), .tx_data(tx_data)
  );

  spi_regif_rxbuf #(.BW(BW)) u_rxb (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .load(rx_done), .frame(rx_frame), .be(bus_be), .rd_view(rx_view)
  );

  always_comb begin
    stat_word = '0;
    stat_word[STAT_RXF_BIT] = rx_full;
    stat_word[STAT_TXE_BIT] = tx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (acc == ACC_STAT) bus_rdata <= stat_word;
    else if (acc == ACC_DRD)  bus_rdata <= rx_view;
  end

  assign tx_valid = !tx_empty;
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_addr,
  input logic [1:0]    bus_be,
  input logic [DW-1:0] bus_rdata,
  input logic          rx_full,
  input logic          tx_empty,
  input logic [DW-1:0] tx_data,
  input logic          tx_take,
  input logic          rx_done
);
  assert_stat_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && !bus_addr) |=> (bus_rdata[DW-1:2] == '0));

  assert_rx_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full) |-> $past(bus_req && !bus_we && bus_addr && bus_be[0]));

  assert_rx_set_R6: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_full);

  assert_tx_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_empty) |-> $past(bus_req && bus_we && bus_addr && bus_be[0]));

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty && !tx_take) |=> (tx_data[7:0] == $past(tx_data[7:0])));

  assert_tx_set_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_take && !tx_empty) |=> tx_empty);
endmodule

bind spi_regif spi_regif_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdata(bus_rdata),
  .rx_full(rx_full), .tx_empty(tx_empty), .tx_data(tx_data),
  .tx_take(tx_take), .rx_done(rx_done)
);

// File: tb/spi_regif_tb.sv
module spi_regif_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rx_full, tx_empty, tx_valid;
  logic [15:0] tx_data;
  logic        tx_take = 1'b0, rx_done = 1'b0;
  logic [15:0] rx_frame = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd;

  always #10 clk = ~clk;

  spi_regif u_dut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_full(rx_full),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_take(tx_take), .rx_done(rx_done), .rx_frame(rx_frame)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic addr, input logic [1:0] be,
                     input logic [15:0] wd, output logic [15:0] r);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    r = bus_rdata;
  endtask

  task automatic frame(input logic [15:0] d);
    @(negedge clk);
    rx_done = 1'b1; rx_frame = d;
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rx_full", {15'b0, rx_full}, 16'h0000);
    check("R1 tx_empty", {15'b0, tx_empty}, 16'h0001);
    check("R1 tx_data", tx_data, 16'h0000);
    check("R1 tx_valid", {15'b0, tx_valid}, 16'h0000);
    check("R1 rdata", bus_rdata, 16'h0000);
  endtask

  task automatic t_tx_noarm();
    bus(1'b1, 1'b1, 2'b01, 16'h0011, rd);
    check("R7 unarmed write keeps tx_empty", {15'b0, tx_empty}, 16'h0001);
    check("R7 unarmed write stores low byte", tx_data, 16'h0011);
  endtask

  task automatic t_status();
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    check("R2 status word", rd, 16'h0002);
  endtask

  task automatic t_rx_narrow();
    wide_mode = 1'b0;
    frame(16'hABCD);
    check("R6 rx_full set", {15'b0, rx_full}, 16'h0001);
    bus(1'b0, 1'b1, 2'b01, '0, rd);
    check("R3 unarmed read data", rd, 16'h00CD);
    check("R3 unarmed read keeps flag", {15'b0, rx_full}, 16'h0001);
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    check("R2 status both flags", rd, 16'h0003);
    bus(1'b0, 1'b1, 2'b11, '0, rd);
    check("R11 narrow read high zero", rd, 16'h00CD);
    check("R3 armed read clears", {15'b0, rx_full}, 16'h0000);
  endtask

  task automatic t_rx_wide();
    wide_mode = 1'b1;
    frame(16'h1234);
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    for (int i = 0; i < 3; i++) begin
      bus(1'b0, 1'b1, 2'b10, '0, rd);
      check("R4 high read data", rd, 16'h1200);
      check("R4 high read keeps flag", {15'b0, rx_full}, 16'h0001);
    end
    bus(1'b0, 1'b1, 2'b01, '0, rd);
    check("R3 low read data", rd, 16'h0034);
    check("R3 low read clears after high reads", {15'b0, rx_full}, 16'h0000);
  endtask

  task automatic t_rx_word();
    frame(16'h5A6B);
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    bus(1'b0, 1'b1, 2'b11, '0, rd);
    check("R5 word read data", rd, 16'h5A6B);
    check("R5 word read clears", {15'b0, rx_full}, 16'h0000);
  endtask

  task automatic t_rx_rearm();
    frame(16'h1111);
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    frame(16'h2222);
    bus(1'b0, 1'b1, 2'b01, '0, rd);
    check("R6 new frame data", rd, 16'h0022);
    check("R6 new frame disarms", {15'b0, rx_full}, 16'h0001);
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    bus(1'b0, 1'b1, 2'b01, '0, rd);
    check("R3 rearmed read clears", {15'b0, rx_full}, 16'h0000);
  endtask

  task automatic t_tx_wide();
    wide_mode = 1'b1;
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    bus(1'b1, 1'b1, 2'b10, 16'hAA00, rd);
    bus(1'b1, 1'b1, 2'b10, 16'hBB00, rd);
    check("R9 high writes keep tx_empty", {15'b0, tx_empty}, 16'h0001);
    bus(1'b1, 1'b1, 2'b01, 16'h0044, rd);
    check("R7 armed low write clears", {15'b0, tx_empty}, 16'h0000);
    check("R9 staged word", tx_data, 16'hBB44);
  endtask

  task automatic t_tx_locked();
    bus(1'b1, 1'b1, 2'b11, 16'hFFFF, rd);
    check("R8 word write ignored", tx_data, 16'hBB44);
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    check("R2 status no flags", rd, 16'h0000);
    bus(1'b1, 1'b1, 2'b10, 16'h7700, rd);
    check("R8 high write ignored", tx_data, 16'hBB44);
    take();
    check("R10 take sets tx_empty", {15'b0, tx_empty}, 16'h0001);
    take();
    check("R10 idle take ignored", {15'b0, tx_empty}, 16'h0001);
    bus(1'b1, 1'b1, 2'b01, 16'h0055, rd);
    check("R10 unarmed after take", {15'b0, tx_empty}, 16'h0001);
  endtask

  task automatic t_tx_word();
    bus(1'b0, 1'b0, 2'b11, '0, rd);
    bus(1'b1, 1'b1, 2'b11, 16'hC3D2, rd);
    check("R9 word write clears", {15'b0, tx_empty}, 16'h0000);
    check("R9 word write data", tx_data, 16'hC3D2);
    wide_mode = 1'b0;
    #1;
    check("R11 narrow tx high zero", tx_data, 16'h00D2);
    take();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_noarm();
    t_status();
    t_rx_narrow();
    t_rx_wide();
    t_rx_word();
    t_rx_rearm();
    t_tx_wide();
    t_tx_locked();
    t_tx_word();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule